// File: doc/BRIEF.md
# Time-of-Day Counter with Alarm

This block keeps wall-clock time from a one-pulse-per-second strobe. A cascade of three counters holds seconds, minutes and hours in 24-hour form. A separate 9-bit counter holds the number of elapsed days. A second set of registers holds an alarm time with the same four fields. One cycle after each second update, the running time is compared with the alarm time.

Software reaches the block through a small register port. A write is a single-cycle strobe, and the read data is combinational from the address. Through this port software loads and reads the time and the alarm, sets the interrupt enables, and clears sticky status flags by writing ones. Four event sources can each raise a status bit: the alarm, the seconds rollover, the minutes rollover and the hours rollover. A single interrupt output is high while any status bit is set together with its enable.

Top module: `tod_alarm_clock`

## Requirements
- R1: After reset, every time, day, alarm, enable and status register reads 0, and `irq` is 0.
- R2: On an accepted tick, the seconds field advances by one. If the seconds value is 59 or higher, it becomes 0 instead and carries into the minutes field. The minutes field follows the same rule on a carry.
- R3: On a carry, the hours field returns to 0 when its value is 23 or higher. Otherwise it advances by one. The return to 0 also increments the day count, and the day count wraps from 511 to 0.
- R4: Address 0 reads the time with seconds in bits [5:0], minutes in bits [13:8] and hours in bits [20:16]. Address 1 reads the day count in bits [8:0]. All other bits read 0, and addresses 6 and 7 read 0 and ignore writes.
- R5: A write to address 0 or address 1 loads the written fields directly. A tick that arrives in the same cycle as either write is discarded, and the next tick counts on from the loaded value.
- R6: Address 2 holds the alarm time, using the same field layout as address 0. Address 3 holds the alarm day in bits [8:0]. Both registers are writable and readable.
- R7: Address 4 holds the interrupt enables. Bit 0 enables the alarm, bit 1 the seconds rollover, bit 2 the minutes rollover and bit 3 the hours rollover. Address 5 holds the status bits, using the same bit positions.
- R8: A rollover status bit is set at the same clock edge as the tick that causes the rollover, and only if its enable bit is set.
- R9: When the alarm is enabled, the alarm status bit is set in the cycle after an accepted tick if all four alarm fields equal the updated time. This happens once per matching second. The alarm stays armed and fires again on any later match.
- R10: Status bits are sticky. Writing a 1 to address 5 clears that bit, and writing a 0 has no effect. If a bit is set and cleared in the same cycle, the set wins.
- R11: `irq` is high exactly when some status bit and its enable bit are both 1. Clearing an enable drops `irq` but keeps the status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of events can land in the same cycle. A tick can arrive together with a write-one-to-clear of the status bit that the same tick sets. A tick can also arrive together with a time load. The bench drives each pair in one cycle: it writes 1 to the seconds-rollover status bit while a tick rolls seconds over 59, and it loads the time while a tick is asserted. It then reads the registers back. In the first case the status bit must stay set. In the second case the loaded value must be unchanged, with no extra count. A behavioural model also runs randomly mixed ticks and writes, so that these collisions recur at arbitrary counter states.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 3;
  localparam int SEC_W    = 6;
  localparam int MIN_W    = 6;
  localparam int HR_W     = 5;
  localparam int SEC_LAST = 59;
  localparam int MIN_LAST = 59;
  localparam int HR_LAST  = 23;
  localparam int NIRQ     = 4;
  localparam int IRQ_ALM  = 0;
  localparam int IRQ_SEC  = 1;
  localparam int IRQ_MIN  = 2;
  localparam int IRQ_HR   = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_TIME  = 3'd0,
    A_DAY   = 3'd1,
    A_ATIME = 3'd2,
    A_ADAY  = 3'd3,
    A_IEN   = 3'd4,
    A_ISTAT = 3'd5
  } reg_addr_e;

  typedef struct packed {
    logic [HR_W-1:0]  hr;
    logic [MIN_W-1:0] mn;
    logic [SEC_W-1:0] sc;
  } hms_t;

  function automatic hms_t unpack_hms(input logic [DATA_W-1:0] w);
    hms_t t;
    t.sc = w[SEC_W-1:0];
    t.mn = w[8 +: MIN_W];
    t.hr = w[16 +: HR_W];
    return t;
  endfunction

  function automatic logic [DATA_W-1:0] pack_hms(input hms_t t);
    logic [DATA_W-1:0] w;
    w = '0;
    w[SEC_W-1:0]  = t.sc;
    w[8 +: MIN_W] = t.mn;
    w[16 +: HR_W] = t.hr;
    return w;
  endfunction

  // a field at or past its last legal value wraps on the next step
  function automatic logic at_last(input logic [31:0] v, input int last);
    return v >= 32'(last);
  endfunction
endpackage

// File: rtl/tod_counter.sv
module tod_counter
  import tod_pkg::*;
#(
  parameter int DAY_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             load_hms,
  input  logic             load_day,
  input  hms_t             hms_in,
  input  logic [DAY_W-1:0] day_in,
  output hms_t             hms_q,
  output logic [DAY_W-1:0] day_q,
  output logic             sec_wrap,
  output logic             min_wrap,
  output logic             hr_wrap
);
  assign sec_wrap = tick_en  & at_last(32'(hms_q.sc), SEC_LAST);
  assign min_wrap = sec_wrap & at_last(32'(hms_q.mn), MIN_LAST);
  assign hr_wrap  = min_wrap & at_last(32'(hms_q.hr), HR_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hms_q <= '0;
      day_q <= '0;
    end else begin
      if (load_hms) begin
        hms_q <= hms_in;
      end else if (tick_en) begin
        hms_q.sc <= sec_wrap ? '0 : hms_q.sc + 1'b1;
        if (sec_wrap) hms_q.mn <= min_wrap ? '0 : hms_q.mn + 1'b1;
        if (min_wrap) hms_q.hr <= hr_wrap ? '0 : hms_q.hr + 1'b1;
      end
      if (load_day)     day_q <= day_in;
      else if (hr_wrap) day_q <= day_q + 1'b1;
    end
  end

  assert_sec_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !load_hms && hms_q.sc == SEC_W'(SEC_LAST)) |=> (hms_q.sc == '0));

  assert_day_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hr_wrap && !load_day) |=> (day_q == $past(day_q) + 1'b1));

  assert_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load_hms |=> (hms_q == $past(hms_in)));
endmodule

// File: rtl/tod_alarm.sv
module tod_alarm
  import tod_pkg::*;
#(
  parameter int DAY_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_hms,
  input  logic             wr_day,
  input  hms_t             hms_in,
  input  logic [DAY_W-1:0] day_in,
  input  hms_t             now_hms,
  input  logic [DAY_W-1:0] now_day,
  input  logic             check,
  output hms_t             alm_hms_q,
  output logic [DAY_W-1:0] alm_day_q,
  output logic             hit
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alm_hms_q <= '0;
      alm_day_q <= '0;
    end else begin
      if (wr_hms) alm_hms_q <= hms_in;
      if (wr_day) alm_day_q <= day_in;
    end
  end

  assign hit = check && (now_hms == alm_hms_q) && (now_day == alm_day_q);

  assert_alarm_regs_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hms |=> $stable(alm_hms_q));
endmodule

// File: rtl/tod_irq.sv
module tod_irq
  import tod_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            wr_clr,
  input  logic [NIRQ-1:0] wdata,
  input  logic [NIRQ-1:0] evt,
  output logic [NIRQ-1:0] en_q,
  output logic [NIRQ-1:0] stat_q,
  output logic            irq
);
  logic [NIRQ-1:0] set_v, clr_v;
  assign set_v = evt & en_q;
  assign clr_v = wr_clr ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      stat_q <= '0;
    end else begin
      if (wr_en) en_q <= wdata;
      stat_q <= (stat_q & ~clr_v) | set_v;
    end
  end

  assign irq = |(stat_q & en_q);

  for (genvar i = 0; i < NIRQ; i++) begin : g_chk
    assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q[i] && !(wr_clr && wdata[i])) |=> stat_q[i]);
    assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (evt[i] && en_q[i]) |=> stat_q[i]);
    assert_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!stat_q[i] && !(evt[i] && en_q[i])) |=> !stat_q[i]);
  end
endmodule

// File: rtl/tod_alarm_clock.sv
module tod_alarm_clock
  import tod_pkg::*;
#(
  parameter int DAY_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1hz,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  logic wr_time, wr_day, wr_atime, wr_aday, wr_ien, wr_istat;
  assign wr_time  = reg_wr && (reg_addr == A_TIME);
  assign wr_day   = reg_wr && (reg_addr == A_DAY);
  assign wr_atime = reg_wr && (reg_addr == A_ATIME);
  assign wr_aday  = reg_wr && (reg_addr == A_ADAY);
  assign wr_ien   = reg_wr && (reg_addr == A_IEN);
  assign wr_istat = reg_wr && (reg_addr == A_ISTAT);

  // a tick colliding with a time or day load is dropped
  logic tick_en, tick_seen;
  assign tick_en = tick_1hz && !wr_time && !wr_day;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick_seen <= 1'b0;
    else        tick_seen <= tick_en;
  end

  hms_t             wr_hms, now_hms, alm_hms;
  logic [DAY_W-1:0] now_day, alm_day;
  logic             sec_wrap, min_wrap, hr_wrap, alm_hit;
  logic [NIRQ-1:0]  evt, en_q, stat_q;

  assign wr_hms = unpack_hms(reg_wdata);

  tod_counter #(.DAY_W(DAY_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .load_hms(wr_time), .load_day(wr_day),
    .hms_in(wr_hms), .day_in(reg_wdata[DAY_W-1:0]),
    .hms_q(now_hms), .day_q(now_day),
    .sec_wrap(sec_wrap), .min_wrap(min_wrap), .hr_wrap(hr_wrap)
  );

  tod_alarm #(.DAY_W(DAY_W)) u_alm (
    .clk(clk), .rst_n(rst_n), .wr_hms(wr_atime), .wr_day(wr_aday),
    .hms_in(wr_hms), .day_in(reg_wdata[DAY_W-1:0]),
    .now_hms(now_hms), .now_day(now_day), .check(tick_seen),
    .alm_hms_q(alm_hms), .alm_day_q(alm_day), .hit(alm_hit)
  );

  always_comb begin
    evt          = '0;
    evt[IRQ_ALM] = alm_hit;
    evt[IRQ_SEC] = sec_wrap;
    evt[IRQ_MIN] = min_wrap;
    evt[IRQ_HR]  = hr_wrap;
  end

  tod_irq u_irq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_ien), .wr_clr(wr_istat),
    .wdata(reg_wdata[NIRQ-1:0]), .evt(evt),
    .en_q(en_q), .stat_q(stat_q), .irq(irq)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_TIME:  reg_rdata = pack_hms(now_hms);
      A_DAY:   reg_rdata = DATA_W'(now_day);
      A_ATIME: reg_rdata = pack_hms(alm_hms);
      A_ADAY:  reg_rdata = DATA_W'(alm_day);
      A_IEN:   reg_rdata = DATA_W'(en_q);
      A_ISTAT: reg_rdata = DATA_W'(stat_q);
      default: reg_rdata = '0;
    endcase
  end

  assert_alarm_after_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    alm_hit |-> $past(tick_en));

  assert_tick_dropped_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_1hz && wr_time) |=> !tick_seen);
endmodule

// File: tb/sim_tod_alarm_clock.sv
module sim_tod_alarm_clock;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_1hz = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tod_alarm_clock u0 (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  // behavioural reference state
  int unsigned s, m, h, d, as_, am, ah, ad, en, st;
  bit td;

  function automatic int unsigned exp_read(input int unsigned a);
    case (a)
      0: return (h << 16) | (m << 8) | s;
      1: return d;
      2: return (ah << 16) | (am << 8) | as_;
      3: return ad;
      4: return en;
      5: return st;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s = 0; m = 0; h = 0; d = 0; as_ = 0; am = 0; ah = 0; ad = 0;
      en = 0; st = 0; td = 0;
    end else begin
      bit wt, wd, te, r_s, r_m, r_h, hitm;
      int unsigned setb, clrb;
      wt = reg_wr && reg_addr == 0;
      wd = reg_wr && reg_addr == 1;
      te = tick_1hz && !wt && !wd;
      r_s = te && s >= 59;
      r_m = r_s && m >= 59;
      r_h = r_m && h >= 23;
      hitm = td && s == as_ && m == am && h == ah && d == ad;
      setb = (hitm ? 1 : 0) | (r_s ? 2 : 0) | (r_m ? 4 : 0) | (r_h ? 8 : 0);
      setb = setb & en;
      clrb = (reg_wr && reg_addr == 5) ? (reg_wdata & 32'hF) : 0;
      st = (st & ~clrb) | setb;
      if (reg_wr && reg_addr == 4) en = reg_wdata & 32'hF;
      if (reg_wr && reg_addr == 2) begin
        as_ = reg_wdata & 32'h3F; am = (reg_wdata >> 8) & 32'h3F; ah = (reg_wdata >> 16) & 32'h1F;
      end
      if (reg_wr && reg_addr == 3) ad = reg_wdata & 32'h1FF;
      if (wt) begin
        s = reg_wdata & 32'h3F; m = (reg_wdata >> 8) & 32'h3F; h = (reg_wdata >> 16) & 32'h1F;
      end else if (te) begin
        s = r_s ? 0 : s + 1;
        if (r_s) m = r_m ? 0 : m + 1;
        if (r_m) h = r_h ? 0 : h + 1;
      end
      if (wd) d = reg_wdata & 32'h1FF;
      else if (r_h) d = (d + 1) % 512;
      td = te;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model, away from the edge
  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      string rq;
      rq = (reg_addr < 2) ? "R4" : (reg_addr < 4) ? "R6" : (reg_addr == 4) ? "R7" : "R10";
      chk(rq, reg_rdata, exp_read(32'(reg_addr)));
      chk("R11", {31'b0, irq}, {31'b0, (st & en) != 0});
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] v);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic tk();
    @(negedge clk);
    tick_1hz = 1'b1;
    @(negedge clk);
    tick_1hz = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input string req, input logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(req, reg_rdata, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    for (int a = 0; a < 8; a++) rd(3'(a), "R1", 32'h0);
    chk("R1", {31'b0, irq}, 32'h0);
    rst_n = 1'b1;

    // full cascade rollover, day wraps 511 -> 0
    wr(3'd4, 32'hF);
    wr(3'd0, 32'h00173B3A);
    wr(3'd1, 32'h1FF);
    tk();
    rd(3'd0, "R2", 32'h00173B3B);
    rd(3'd5, "R8", 32'h0);
    tk();
    rd(3'd0, "R3", 32'h0);
    rd(3'd1, "R3", 32'h0);
    // rollovers at the edge, alarm at 0/00:00:00 one cycle later
    rd(3'd5, "R8", 32'hF);
    wr(3'd5, 32'h2);
    rd(3'd5, "R10", 32'hD);
    wr(3'd5, 32'h0);
    rd(3'd5, "R10", 32'hD);
    wr(3'd5, 32'hF);
    rd(3'd5, "R10", 32'h0);

    // alarm match and re-arm
    wr(3'd0, 32'h000A141D);
    wr(3'd1, 32'd5);
    wr(3'd2, 32'h000A141E);
    wr(3'd3, 32'd5);
    rd(3'd2, "R6", 32'h000A141E);
    rd(3'd3, "R6", 32'd5);
    tk();
    rd(3'd5, "R9", 32'h1);
    chk("R11", {31'b0, irq}, 32'h1);
    wr(3'd5, 32'h1);
    tk();
    rd(3'd5, "R9", 32'h0);
    wr(3'd0, 32'h000A141D);
    tk();
    rd(3'd5, "R9", 32'h1);
    wr(3'd5, 32'hF);

    // tick colliding with a time load is discarded
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 32'h5; tick_1hz = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; tick_1hz = 1'b0;
    rd(3'd0, "R5", 32'h5);
    tk();
    rd(3'd0, "R5", 32'h6);

    // set and clear of the same status bit in one cycle
    wr(3'd4, 32'h2);
    wr(3'd0, 32'h3B);
    wr(3'd5, 32'hF);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'd5; reg_wdata = 32'h2; tick_1hz = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; tick_1hz = 1'b0;
    rd(3'd5, "R10", 32'h2);
    chk("R11", {31'b0, irq}, 32'h1);
    wr(3'd4, 32'h0);
    rd(3'd5, "R11", 32'h2);
    chk("R11", {31'b0, irq}, 32'h0);

    // disabled rollover leaves status alone
    wr(3'd5, 32'hF);
    wr(3'd0, 32'h3B);
    tk();
    rd(3'd5, "R8", 32'h0);
    rd(3'd0, "R2", 32'h100);

    // out-of-range loaded fields, unused bits
    wr(3'd0, 32'hFFFFFFFF);
    rd(3'd0, "R4", 32'h001F3F3F);
    wr(3'd6, 32'hFFFFFFFF);
    rd(3'd6, "R4", 32'h0);
    tk();
    rd(3'd0, "R2", 32'h0);
    rd(3'd1, "R3", 32'd6);

    // random mix against the model
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      tick_1hz = ($urandom % 3) == 0;
      reg_wr = ($urandom % 6) == 0;
      reg_addr = 3'($urandom % 8);
      reg_wdata = (reg_addr == 3'd5 || reg_addr == 3'd4) ? 32'($urandom % 16) :
                  (reg_addr == 3'd2) ? ((h << 16) | (m << 8) | ((s + 1) % 60)) :
                  (reg_addr == 3'd3) ? d : $urandom;
    end
    @(negedge clk);
    tick_1hz = 1'b0; reg_wr = 1'b0;
    repeat (2) @(negedge clk);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule